// File: doc/BRIEF.md
# Circular Register Window File

This block is an integer register file for a processor that gives each procedure its own window of registers. Software sees 32 logical registers. Eight of them are globals, shared by every procedure. The other 24 form three groups of eight: ins, locals and outs. A call strobe moves the block to a fresh window, and the caller's outs become the callee's ins. A return strobe moves back to the caller's window.

The physical windows sit in a ring of eight blocks, and the window pointer wraps modulo eight. Software never sees the physical position, so it never sees the wrap. When a call would reuse a block that a live window still owns, the block stalls. It then asks a memory-side sequencer to save the oldest half of the resident windows. It asks for one window at a time and waits for each save to be acknowledged. After the last save, the call completes in the freed space.

A return into a window whose contents were saved works the same way. The block stalls and asks for that one window to be restored, then completes the return. The sequencer moves data through a hidden word port that addresses the requested window.

Top module: `rwin_file`

## Requirements
- R1: Logical register 0 to 7 is a global shared by all windows. Registers 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. A write lands on the clock edge, and a later read of the same register in the same window returns the written value.
- R2: After a call, the callee's ins (24 to 31) hold what the caller last wrote to its outs (8 to 15). Callee writes to its ins are seen in the caller's outs after the return.
- R3: A read of the register being written in the same cycle returns the new write data.
- R4: A call made while seven windows are resident raises `stall` and `spill_req` from the next cycle. The block then saves NWIN/2 windows, oldest first. It takes one window per cycle in which `spill_done` is high, and consecutive `spill_win` values rise by one modulo 8.
- R5: Once the saves end, the call completes and the pointer wraps around the ring. Every global and every value held by a resident window reads back unchanged.
- R6: A return made while only one window is resident and saved windows exist raises `stall` and `fill_req` with `fill_win` naming the most recently saved window. The stall holds until `fill_done`, and then the return completes.
- R7: A return made at the outermost window with nothing saved is ignored. No stall occurs and the window is unchanged.
- R8: After reset every register reads zero, and `stall`, `spill_req` and `fill_req` are low.
- R9: `stall` is high exactly while a save or restore is in progress. Call and return strobes are ignored during that time, and when both strobes are high in an idle cycle the call wins.
- R10: While `spill_req` is high, `bk_rdata` returns word `bk_addr` of window `spill_win`. Words 0 to 7 are that window's ins and words 8 to 15 are its locals. While `fill_req` is high, `bk_we` writes `bk_wdata` to the same word of `fill_win`, so a save and a later restore of a window return its exact contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_addr | input | 5 | Logical register for read port A |
| ra_data | output | DW | Read port A data |
| rb_addr | input | 5 | Logical register for read port B |
| rb_data | output | DW | Read port B data |
| we | input | 1 | Write enable |
| waddr | input | 5 | Logical register to write |
| wdata | input | DW | Write data |
| call | input | 1 | Move to a new window |
| ret | input | 1 | Move back to the caller's window |
| stall | output | 1 | Save or restore in progress |
| spill_req | output | 1 | Request to save a window |
| spill_win | output | log2(NWIN) | Physical window to save |
| spill_done | input | 1 | Current window save finished |
| fill_req | output | 1 | Request to restore a window |
| fill_win | output | log2(NWIN) | Physical window to restore |
| fill_done | input | 1 | Restore finished |
| bk_addr | input | 4 | Word within the requested window |
| bk_rdata | output | DW | Word read for a save |
| bk_we | input | 1 | Word write for a restore |
| bk_wdata | input | DW | Word data for a restore |

## Verification
The bench drives deep call chains until the ring wraps, then unwinds them through several restores. A design that saved the wrong block, or saved in the wrong order, would restore stale values, and the reads after each return would differ from the model. Returns at the outermost window and calls or returns issued during a stall are mixed into the stimulus. A design that honoured them would move its window and show different ins and locals. Same-cycle read-after-write and call-return collisions are also exercised. A design without forwarding would return the old value, and a design that gave priority to the return would unwind instead of nesting.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int LREG_W   = 5;   // logical register number width
    localparam int GRP_REGS = 8;   // registers per group
    localparam int BK_W     = 4;   // word index within one physical block
    localparam int BLK_REGS = 1 << BK_W;

    // upper two bits of a logical register select its group
    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_OUT = 2'd1,
        GRP_LOC = 2'd2,
        GRP_IN  = 2'd3
    } lgrp_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } wstate_e;

    typedef struct packed {
        logic              en;
        logic [LREG_W-1:0] addr;
    } wreq_t;

    function automatic lgrp_e grp_of(input logic [LREG_W-1:0] a);
        return lgrp_e'(a[LREG_W-1 -: 2]);
    endfunction

endpackage

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter  int NWIN  = 8,
    parameter  int CNT_W = 16,
    localparam int WIN_W = $clog2(NWIN),
    localparam int SPILL_N = NWIN / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             call,
    input  logic             ret,
    input  logic             spill_done,
    input  logic             fill_done,
    output logic [WIN_W-1:0] cwp,
    output logic             stall,
    output logic             spill_req,
    output logic [WIN_W-1:0] spill_win,
    output logic             fill_req,
    output logic [WIN_W-1:0] fill_win
);

    localparam logic [WIN_W-1:0] ONE  = WIN_W'(1);
    localparam logic [WIN_W-1:0] FULL = WIN_W'(NWIN - 1);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(SPILL_N - 1);

    wstate_e          st;
    logic [WIN_W-1:0] res;      // resident windows, 1 .. NWIN-1
    logic [WIN_W-1:0] left;     // saves still owed after this one
    logic [CNT_W-1:0] spilled;  // windows held in memory

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_RUN;
            cwp     <= '0;
            res     <= ONE;
            left    <= '0;
            spilled <= '0;
        end else begin
            unique case (st)
                ST_RUN: begin
                    if (call) begin
                        if (res == FULL) begin
                            st   <= ST_SPILL;
                            left <= LAST;
                        end else begin
                            cwp <= cwp + ONE;
                            res <= res + ONE;
                        end
                    end else if (ret) begin
                        if (res != ONE) begin
                            cwp <= cwp - ONE;
                            res <= res - ONE;
                        end else if (spilled != '0) begin
                            st <= ST_FILL;
                        end
                    end
                end
                ST_SPILL: begin
                    if (spill_done) begin
                        spilled <= spilled + 1'b1;
                        if (left == '0) begin
                            // pending call completes in the freed block
                            cwp <= cwp + ONE;
                            st  <= ST_RUN;
                        end else begin
                            res  <= res - ONE;
                            left <= left - ONE;
                        end
                    end
                end
                ST_FILL: begin
                    if (fill_done) begin
                        spilled <= spilled - 1'b1;
                        cwp     <= cwp - ONE;
                        st      <= ST_RUN;
                    end
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    assign stall     = (st != ST_RUN);
    assign spill_req = (st == ST_SPILL);
    assign fill_req  = (st == ST_FILL);
    assign spill_win = cwp - res + ONE;   // oldest resident window
    assign fill_win  = cwp - ONE;

    // R4
    spill_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spill_req) |-> $past(call));

    // R4
    spill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (spill_req && spill_done && left != '0) |=>
            (spill_req && spill_win == WIN_W'($past(spill_win) + ONE)));

    // R6
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_done) |=> (fill_req && $stable(fill_win)));

    // R9
    stall_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !spill_done && !fill_done) |=> $stable(cwp));

    // R5
    res_range_chk: assert property (@(posedge clk) disable iff (rst)
        (res != '0) && (res <= FULL));

endmodule

// File: rtl/rwin_store.sv
module rwin_store
    import rwin_pkg::*;
#(
    parameter  int NWIN  = 8,
    parameter  int DW    = 32,
    localparam int WIN_W = $clog2(NWIN),
    localparam int PA_W  = WIN_W + BK_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [WIN_W-1:0]           cwp,
    input  wreq_t                      wr,
    input  logic [DW-1:0]              wdata,
    input  logic [1:0][LREG_W-1:0]     raddr,
    output logic [1:0][DW-1:0]         rdata,
    input  logic [WIN_W-1:0]           spill_win,
    input  logic [WIN_W-1:0]           fill_win,
    input  logic [BK_W-1:0]            bk_addr,
    input  logic                       bk_en,
    input  logic [DW-1:0]              bk_wdata,
    output logic [DW-1:0]              bk_rdata
);

    typedef struct packed {
        logic            glob;
        logic [PA_W-1:0] idx;
    } key_t;

    // block w: words 0..7 are window w's ins, 8..15 its locals;
    // window w's outs are the ins of block w+1
    function automatic key_t key_of(input logic [WIN_W-1:0] w,
                                    input logic [LREG_W-1:0] a);
        key_t k;
        k.glob = 1'b0;
        unique case (grp_of(a))
            GRP_GLB: begin
                k.glob = 1'b1;
                k.idx  = PA_W'(a[2:0]);
            end
            GRP_OUT: k.idx = {WIN_W'(w + 1'b1), 1'b0, a[2:0]};
            GRP_LOC: k.idx = {w, 1'b1, a[2:0]};
            default: k.idx = {w, 1'b0, a[2:0]};
        endcase
        return k;
    endfunction

    logic [DW-1:0] glb [GRP_REGS];
    logic [DW-1:0] win [NWIN*BLK_REGS];

    key_t wk;
    assign wk = key_of(cwp, wr.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GRP_REGS; i++) glb[i] <= '0;
            for (int i = 0; i < NWIN*BLK_REGS; i++) win[i] <= '0;
        end else begin
            if (wr.en) begin
                if (wk.glob) glb[wk.idx[2:0]] <= wdata;
                else         win[wk.idx]      <= wdata;
            end
            if (bk_en) win[{fill_win, bk_addr}] <= bk_wdata;
        end
    end

    assign bk_rdata = win[{spill_win, bk_addr}];

    for (genvar p = 0; p < 2; p++) begin : g_rd
        key_t          rk;
        logic [DW-1:0] held;
        assign rk    = key_of(cwp, raddr[p]);
        assign held  = rk.glob ? glb[rk.idx[2:0]] : win[rk.idx];
        assign rdata[p] = (wr.en && wr.addr == raddr[p]) ? wdata : held;

        // R1
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            wr.en |=> ((rk != $past(wk)) || (wr.en && wk == rk) ||
                       (rdata[p] == $past(wdata))));
    end

endmodule

// File: rtl/rwin_file.sv
module rwin_file
    import rwin_pkg::*;
#(
    parameter  int NWIN  = 8,
    parameter  int DW    = 32,
    localparam int WIN_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       ra_addr,
    output logic [DW-1:0]    ra_data,
    input  logic [4:0]       rb_addr,
    output logic [DW-1:0]    rb_data,
    input  logic             we,
    input  logic [4:0]       waddr,
    input  logic [DW-1:0]    wdata,
    input  logic             call,
    input  logic             ret,
    output logic             stall,
    output logic             spill_req,
    output logic [WIN_W-1:0] spill_win,
    input  logic             spill_done,
    output logic             fill_req,
    output logic [WIN_W-1:0] fill_win,
    input  logic             fill_done,
    input  logic [3:0]       bk_addr,
    output logic [DW-1:0]    bk_rdata,
    input  logic             bk_we,
    input  logic [DW-1:0]    bk_wdata
);

    logic [WIN_W-1:0]       cwp;
    logic [1:0][LREG_W-1:0] raddr;
    logic [1:0][DW-1:0]     rdata;
    wreq_t                  wr;

    assign raddr[0] = ra_addr;
    assign raddr[1] = rb_addr;
    assign ra_data  = rdata[0];
    assign rb_data  = rdata[1];
    assign wr.en    = we;
    assign wr.addr  = waddr;

    rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .call      (call),
        .ret       (ret),
        .spill_done(spill_done),
        .fill_done (fill_done),
        .cwp       (cwp),
        .stall     (stall),
        .spill_req (spill_req),
        .spill_win (spill_win),
        .fill_req  (fill_req),
        .fill_win  (fill_win)
    );

    rwin_store #(.NWIN(NWIN), .DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cwp      (cwp),
        .wr       (wr),
        .wdata    (wdata),
        .raddr    (raddr),
        .rdata    (rdata),
        .spill_win(spill_win),
        .fill_win (fill_win),
        .bk_addr  (bk_addr),
        .bk_en    (bk_we && fill_req),
        .bk_wdata (bk_wdata),
        .bk_rdata (bk_rdata)
    );

endmodule

// File: tb/tb_rwin_file.sv
module tb_rwin_file;

    localparam int CLK_PERIOD = 100;
    localparam int NWIN = 8;
    localparam int DW   = 32;
    localparam int MAXF = 64;

    logic clk, rst;
    logic [4:0] ra_addr, rb_addr, waddr;
    logic [DW-1:0] ra_data, rb_data, wdata, bk_rdata, bk_wdata;
    logic we, call, ret, stall, spill_req, fill_req, spill_done, fill_done, bk_we;
    logic [2:0] spill_win, fill_win;
    logic [3:0] bk_addr;

    rwin_file #(.NWIN(NWIN), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data),
        .we(we), .waddr(waddr), .wdata(wdata),
        .call(call), .ret(ret), .stall(stall),
        .spill_req(spill_req), .spill_win(spill_win), .spill_done(spill_done),
        .fill_req(fill_req), .fill_win(fill_win), .fill_done(fill_done),
        .bk_addr(bk_addr), .bk_rdata(bk_rdata), .bk_we(bk_we), .bk_wdata(bk_wdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural model: a stack of frames, frame d = 8 ins then 8 locals
    int cur, res, spilled, mst, left;
    logic [31:0] gv [8];
    logic [31:0] fv [MAXF*16];
    bit          fk [MAXF*16];
    int checks, errors, nbursts, nfills, fcnt, last_win;
    bit sp_prev, in_reset_phase, r7_flag;
    logic [31:0] sdata [$];
    int          sidx  [$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic int fidx(input logic [4:0] a);
        case (a[4:3])
            2'd1:    return (cur + 1) * 16 + int'(a[2:0]);
            2'd2:    return cur * 16 + 8 + int'(a[2:0]);
            default: return cur * 16 + int'(a[2:0]);
        endcase
    endfunction

    task automatic exp_reg(input logic [4:0] a, output logic [31:0] v, output bit k);
        if (a[4:3] == 2'd0) begin
            v = gv[a[2:0]];
            k = 1'b1;
        end else begin
            v = fv[fidx(a)];
            k = fk[fidx(a)];
        end
    endtask

    task automatic do_call();
        cur++;
        res++;
        for (int i = 8; i < 16; i++) fk[cur*16 + i] = 1'b0;
        for (int i = 0; i < 8; i++)  fk[(cur+1)*16 + i] = 1'b0;
    endtask

    task automatic model_update(input bit c, input bit r, input bit w,
                                input logic [4:0] wa, input logic [31:0] wd);
        r7_flag = 1'b0;
        if (w) begin
            if (wa[4:3] == 2'd0) gv[wa[2:0]] = wd;
            else begin
                fv[fidx(wa)] = wd;
                fk[fidx(wa)] = 1'b1;
            end
        end
        case (mst)
            0: begin
                if (c) begin
                    if (res == NWIN - 1) begin
                        mst = 1;
                        left = NWIN / 2;
                        nbursts++;
                    end else do_call();
                end else if (r) begin
                    if (res > 1) begin
                        cur--;
                        res--;
                    end else if (spilled > 0) begin
                        mst = 2;
                        nfills++;
                    end else r7_flag = 1'b1;
                end
            end
            1: if (spill_done) begin
                res--;
                spilled++;
                left--;
                if (left == 0) begin
                    do_call();
                    mst = 0;
                end
            end
            default: if (fill_done) begin
                spilled--;
                cur--;
                mst = 0;
            end
        endcase
    endtask

    task automatic cycle(input bit c, input bit r, input bit w, input logic [4:0] wa,
                         input logic [31:0] wd, input logic [4:0] a0, input logic [4:0] a1);
        logic [31:0] ev;
        logic [31:0] act;
        logic [4:0]  ad;
        bit          ek;
        string       tg;
        @(negedge clk);
        spill_done = 1'b0; fill_done = 1'b0; bk_we = 1'b0;
        bk_addr = '0; bk_wdata = '0;
        if (spill_req) begin
            if (sp_prev) chk("R4", "spill window step", 32'(spill_win), 32'((last_win + 1) % NWIN));
            for (int i = 0; i < 16; i++) begin
                bk_addr = 4'(i);
                #1;
                sdata.push_back(bk_rdata);
                if (mst == 1 && fk[(cur - res + 1)*16 + i])
                    chk("R10", "saved word", bk_rdata, fv[(cur - res + 1)*16 + i]);
            end
            sidx.push_back(int'(spill_win));
            last_win = int'(spill_win);
            spill_done = 1'b1;
            sp_prev = 1'b1;
        end else begin
            sp_prev = 1'b0;
            if (fill_req) begin
                if (sidx.size() == 0) begin
                    chk("R6", "restore with nothing saved", 32'(fill_win), 32'hffffffff);
                    fill_done = 1'b1;
                end else if (fcnt == 0) begin
                    chk("R6", "restore window", 32'(fill_win), 32'(sidx[$]));
                end
                if (sidx.size() != 0) begin
                    if (fcnt < 16) begin
                        bk_we = 1'b1;
                        bk_addr = 4'(fcnt);
                        bk_wdata = sdata[sdata.size() - 16 + fcnt];
                        fcnt++;
                    end else begin
                        fill_done = 1'b1;
                        fcnt = 0;
                        for (int i = 0; i < 16; i++) void'(sdata.pop_back());
                        void'(sidx.pop_back());
                    end
                end
            end
        end
        call = c; ret = r; we = w; waddr = wa; wdata = wd;
        ra_addr = a0; rb_addr = a1;
        #2;
        chk(in_reset_phase ? "R8" : (r7_flag ? "R7" : "R9"), "stall", 32'(stall), 32'(mst != 0));
        chk(in_reset_phase ? "R8" : "R4", "spill_req", 32'(spill_req), 32'(mst == 1));
        chk(in_reset_phase ? "R8" : "R6", "fill_req", 32'(fill_req), 32'(mst == 2));
        for (int p = 0; p < 2; p++) begin
            ad  = (p == 0) ? a0 : a1;
            act = (p == 0) ? ra_data : rb_data;
            exp_reg(ad, ev, ek);
            if (w && wa == ad) begin
                ev = wd; ek = 1'b1; tg = "R3";
            end else if (in_reset_phase) tg = "R8";
            else if (ad[4:3] == 2'd0) tg = "R1";
            else if (ad[4:3] == 2'd3) tg = "R2";
            else if (nbursts > 0) tg = "R5";
            else tg = "R1";
            if (ek) chk(tg, $sformatf("read r%0d", ad), act, ev);
        end
        @(posedge clk);
        model_update(c, r, w, wa, wd);
    endtask

    task automatic rand_phase(input int n, input int callpct, input int retpct);
        bit c, r, w;
        for (int k = 0; k < n; k++) begin
            c = (($urandom % 100) < callpct) && (cur < 48);
            r = (($urandom % 100) < retpct);
            w = ($urandom % 100) < 60;
            cycle(c, r, w, 5'($urandom), $urandom, 5'($urandom), 5'($urandom));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        checks = 0; errors = 0; nbursts = 0; nfills = 0; fcnt = 0; last_win = 0;
        cur = 0; res = 1; spilled = 0; mst = 0; left = 0;
        sp_prev = 0; r7_flag = 0; in_reset_phase = 1;
        for (int i = 0; i < 8; i++) gv[i] = '0;
        for (int i = 0; i < MAXF*16; i++) begin
            fv[i] = '0;
            fk[i] = (i < 32);
        end
        call = 0; ret = 0; we = 0; waddr = 0; wdata = 0; ra_addr = 0; rb_addr = 0;
        spill_done = 0; fill_done = 0; bk_we = 0; bk_addr = 0; bk_wdata = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: every register reads zero after reset
        for (int i = 0; i < 16; i++) cycle(0, 0, 0, 0, 0, 5'(i), 5'(31 - i));
        in_reset_phase = 0;
        // R7: returns at the outermost window with nothing saved
        cycle(0, 1, 1, 5'd24, 32'hA5A5_0001, 5'd24, 5'd16);
        cycle(0, 1, 0, 0, 0, 5'd24, 5'd8);
        // R2: outs pass to the callee's ins
        cycle(0, 0, 1, 5'd9, 32'h1234_5678, 5'd9, 5'd1);
        cycle(1, 0, 0, 0, 0, 5'd25, 5'd9);
        cycle(0, 0, 1, 5'd25, 32'hCAFE_0002, 5'd25, 5'd25);
        cycle(0, 1, 0, 0, 0, 5'd25, 5'd9);
        cycle(0, 0, 0, 0, 0, 5'd9, 5'd25);
        // R9: call wins over a simultaneous return
        cycle(1, 1, 0, 0, 0, 5'd25, 5'd9);
        cycle(0, 0, 0, 0, 0, 5'd25, 5'd9);
        // R4 R5 R6: nest deep, unwind, then mix
        rand_phase(1500, 75, 5);
        rand_phase(2500, 5, 75);
        rand_phase(3000, 45, 45);
        rand_phase(1500, 70, 20);
        rand_phase(2500, 10, 70);
        repeat (40) cycle(0, 0, 0, 0, 0, 5'($urandom), 5'($urandom));
        chk("R5", "overflow bursts seen", 32'(nbursts > 0), 32'd1);
        chk("R6", "restores seen", 32'(nfills > 0), 32'd1);
        summary();
        $finish;
    end

endmodule